// File: doc/BRIEF.md
# Saturating Fixed-Point Coefficient Multiplier

This block multiplies a signed fixed-point coefficient by a signed fixed-point operand and returns the product in a third fixed-point format. Each of the three formats has its own integer-bit count (sign included) and fraction-bit count. The product is re-aligned to the output binary point by dropping low fraction bits. The integer part is then clamped to the output range, so an out-of-range product does not wrap.

A caller places the coefficient and the operand on the inputs and raises `arm`. On the edge that samples `arm` high, the block captures both values. It then runs a shift-add multiplication, one operand bit per cycle, and raises `finished` once `result` is valid. The result and `finished` stay unchanged while `arm` remains high. Dropping `arm` clears `finished` and makes the block ready for the next operation.

Default formats: coefficient 8.40 (48 bits), operand 12.8 (20 bits), output 16.40 (56 bits). With these defaults, 8 low bits are dropped from the 68-bit full product and 4 high integer bits are saturated away.

Top module: `fxm_sat_mul`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `finished` is 0 and `result` is 0.
- R2: All values are two's complement. A completed `result` equals floor(coef × opnd / 2^(CF_BITS + OF_BITS − YF_BITS)), where coef and opnd are the raw signed integers, whenever that value lies inside the output range.
- R3: Dropped low fraction bits are truncated toward negative infinity. For example, a coefficient of one LSB times an operand of minus one LSB gives an output of all ones, which is −1 output LSB.
- R4: A result above the output range is clamped to the most positive output code: sign bit 0 and all other bits 1.
- R5: A result below the output range is clamped to the most negative output code: sign bit 1 and all other bits 0.
- R6: `finished` rises exactly OI_BITS+OF_BITS+1 clock cycles after the edge that samples `arm` high while the block is idle.
- R7: While `arm` stays high after completion, `finished` stays 1 and `result` stays constant. Input changes do not start a new operation.
- R8: `finished` is 0 on the edge after the one that samples `arm` low. If `arm` is raised again on the next cycle, a new operation starts normally.
- R9: The coefficient and operand are captured on the arming edge. Changing the inputs during the operation does not alter the result.
- R10: A zero coefficient or a zero operand gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Start request; held high until the result has been taken |
| coef | input | CI_BITS+CF_BITS | Signed coefficient |
| opnd | input | OI_BITS+OF_BITS | Signed operand |
| finished | output | 1 | Result is valid |
| result | output | YI_BITS+YF_BITS | Signed, rescaled, saturated product |

## Verification
A wrong internal state shows up at the ports no later than the rise of `finished`. An accumulator slip or a miscounted bit gives a wrong `result` value. A bad step counter moves the rise of `finished` away from its exact cycle. A faulty saturation decision turns an overflow into a wrapped value whose sign disagrees with the true product. A handshake fault shows up within one cycle of an `arm` change: `finished` fails to clear, or `result` moves while it should hold.

// File: rtl/fxm_pkg.sv
// Package: shared types for the saturating fixed-point multiplier.
// Assumes: nothing beyond standard SystemVerilog.
package fxm_pkg;

    // Handshake sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } fxm_state_e;

endpackage

// File: rtl/fxm_seqmul.sv
// Module: fxm_seqmul
// Radix-2 signed shift-add multiplier. It takes one multiplier bit per cycle
// and subtracts the partial product for the sign bit.
// Assumes: start is a one-cycle pulse given only while the core is idle.
// Produces A_W+B_W product bits; done pulses on the cycle the product is final.
module fxm_seqmul #(
    parameter int A_W = 48,
    parameter int B_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [A_W-1:0]       a_in,
    input  logic [B_W-1:0]       b_in,
    output logic                 done,
    output logic [A_W+B_W-1:0]   prod
);
    localparam int P_W = A_W + B_W;
    localparam int C_W = $clog2(B_W + 1);
    localparam logic [C_W-1:0] LAST = C_W'(B_W - 1);

    logic [P_W-1:0] mcand;
    logic [B_W-1:0] mplier;
    logic [P_W-1:0] acc;
    logic [C_W-1:0] step;
    logic           busy;
    logic [P_W-1:0] addend;
    logic [P_W-1:0] acc_nx;

    // Select the partial product: add for value bits, subtract for the sign bit.
    always_comb begin
        addend = mplier[0] ? mcand : '0;
        acc_nx = (step == LAST) ? (acc - addend) : (acc + addend);
    end

    // Capture operands on start, then accumulate one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            step   <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else if (start) begin
            mcand  <= {{B_W{a_in[A_W-1]}}, a_in};
            mplier <= b_in;
            acc    <= '0;
            step   <= '0;
            busy   <= 1'b1;
            done   <= 1'b0;
        end else if (busy) begin
            acc    <= acc_nx;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            step   <= step + 1'b1;
            busy   <= (step != LAST);
            done   <= (step == LAST);
        end else begin
            done   <= 1'b0;
        end
    end

    assign prod = acc;

    // R6: the step counter never passes the last operand bit.
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step <= LAST));

    // R6: completion is reported only after the core leaves the busy state.
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/fxm_rescale.sv
// Module: fxm_rescale
// Moves a full-width signed product to the output format. It drops DROP low
// bits (arithmetic shift, so truncation toward negative infinity) and clamps
// the remaining integer part to Y_W bits.
// Assumes: DROP >= 0 and P_W > DROP. Purely combinational.
module fxm_rescale #(
    parameter int P_W  = 68,
    parameter int DROP = 8,
    parameter int Y_W  = 56
) (
    input  logic [P_W-1:0] prod,
    output logic [Y_W-1:0] y,
    output logic           ovf
);
    localparam int SH_W = P_W - DROP;
    localparam logic [Y_W-1:0] Y_MAX = {1'b0, {(Y_W-1){1'b1}}};
    localparam logic [Y_W-1:0] Y_MIN = {1'b1, {(Y_W-1){1'b0}}};

    logic [SH_W-1:0] sh;
    assign sh = prod[P_W-1:DROP];

    generate
        if (SH_W > Y_W) begin : g_narrow
            logic [SH_W-Y_W:0] hi;
            assign hi = sh[SH_W-1:Y_W-1];
            // Clamp when the discarded bits are not all copies of the kept sign.
            always_comb begin
                ovf = !((&hi) || !(|hi));
                if (ovf) y = sh[SH_W-1] ? Y_MIN : Y_MAX;
                else     y = sh[Y_W-1:0];
            end
        end else if (SH_W == Y_W) begin : g_equal
            // Formats line up: pass through.
            always_comb begin
                ovf = 1'b0;
                y   = sh;
            end
        end else begin : g_wide
            // Output is wider: sign-extend.
            always_comb begin
                ovf = 1'b0;
                y   = {{(Y_W-SH_W){sh[SH_W-1]}}, sh};
            end
        end
    endgenerate

endmodule

// File: rtl/fxm_ctrl.sv
// Module: fxm_ctrl
// Arm/finished sequencer. Starts the core from idle on arm, latches the result
// when the core reports done, and holds it until arm is released.
// Assumes: core_done pulses exactly once per start.
module fxm_ctrl
    import fxm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic core_done,
    output logic start,
    output logic latch,
    output logic finished
);
    fxm_state_e state;

    // Decode the start and latch strobes from the current state.
    always_comb begin
        start = (state == ST_IDLE) && arm;
        latch = (state == ST_RUN) && core_done;
    end

    // Advance the handshake state and drive finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            finished <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (arm) state <= ST_RUN;
                ST_RUN:  if (core_done) begin
                             state    <= ST_HOLD;
                             finished <= 1'b1;
                         end
                ST_HOLD: if (!arm) begin
                             state    <= ST_IDLE;
                             finished <= 1'b0;
                         end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: finished drops on the edge after arm is seen low.
    fin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finished && !arm) |=> !finished);

    // R7: no new start is issued while a result is being held.
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> !start);

endmodule

// File: rtl/fxm_sat_mul.sv
// Module: fxm_sat_mul (top)
// Saturating fixed-point coefficient multiplier with an arm/finished handshake.
// Coefficient CI.CF times operand OI.OF gives output YI.YF, truncated low
// and saturated high.
// Assumes: CF_BITS + OF_BITS >= YF_BITS; arm is held until finished is seen.
module fxm_sat_mul #(
    parameter int CI_BITS = 8,
    parameter int CF_BITS = 40,
    parameter int OI_BITS = 12,
    parameter int OF_BITS = 8,
    parameter int YI_BITS = 16,
    parameter int YF_BITS = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          arm,
    input  logic [CI_BITS+CF_BITS-1:0]    coef,
    input  logic [OI_BITS+OF_BITS-1:0]    opnd,
    output logic                          finished,
    output logic [YI_BITS+YF_BITS-1:0]    result
);
    localparam int K_W  = CI_BITS + CF_BITS;
    localparam int X_W  = OI_BITS + OF_BITS;
    localparam int Y_W  = YI_BITS + YF_BITS;
    localparam int P_W  = K_W + X_W;
    localparam int DROP = CF_BITS + OF_BITS - YF_BITS;

    logic           start;
    logic           latch;
    logic           core_done;
    logic [P_W-1:0] prod;
    logic [Y_W-1:0] y_next;
    logic           ovf;

    fxm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .core_done(core_done),
        .start    (start),
        .latch    (latch),
        .finished (finished)
    );

    fxm_seqmul #(.A_W(K_W), .B_W(X_W)) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .a_in (coef),
        .b_in (opnd),
        .done (core_done),
        .prod (prod)
    );

    fxm_rescale #(.P_W(P_W), .DROP(DROP), .Y_W(Y_W)) u_rescale (
        .prod(prod),
        .y   (y_next),
        .ovf (ovf)
    );

    // Register the rescaled product when the sequencer latches it.
    always_ff @(posedge clk) begin
        if (!rst_n)     result <= '0;
        else if (latch) result <= y_next;
    end

    // R4 R5: a clamped or exact result keeps the sign of the true product.
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(finished) |-> (result[Y_W-1] == $past(prod[P_W-1])));

    // R7: the result stays put while finished remains high.
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finished && $past(finished)) |-> $stable(result));

    // R1: the edge after a reset leaves finished low.
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !finished);

endmodule

// File: tb/fxm_sat_mul_test.sv
// Directed bench for fxm_sat_mul: one task per scenario, each checking itself.
module fxm_sat_mul_test;
    localparam int CI = 8, CF = 40, OI = 12, OF = 8, YI = 16, YF = 40;
    localparam int K_W = CI + CF;
    localparam int X_W = OI + OF;
    localparam int Y_W = YI + YF;
    localparam int DROP = CF + OF - YF;
    localparam logic [Y_W-1:0] Y_MAX = {1'b0, {(Y_W-1){1'b1}}};
    localparam logic [Y_W-1:0] Y_MIN = {1'b1, {(Y_W-1){1'b0}}};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arm = 1'b0;
    logic [K_W-1:0] coef = '0;
    logic [X_W-1:0] opnd = '0;
    logic           finished;
    logic [Y_W-1:0] result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fxm_sat_mul #(
        .CI_BITS(CI), .CF_BITS(CF), .OI_BITS(OI),
        .OF_BITS(OF), .YI_BITS(YI), .YF_BITS(YF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .coef(coef),
        .opnd(opnd), .finished(finished), .result(result)
    );

    // Independent reference built from the requirement formulas.
    function automatic logic [Y_W-1:0] ref_mul(input logic [K_W-1:0] k,
                                               input logic [X_W-1:0] x);
        logic signed [127:0] p, hi, lo;
        p  = $signed(k) * $signed(x);
        p  = p >>> DROP;
        hi = (128'sd1 <<< (Y_W - 1)) - 128'sd1;
        lo = -(128'sd1 <<< (Y_W - 1));
        if (p > hi) return Y_MAX;
        if (p < lo) return Y_MIN;
        return p[Y_W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arm, count edges to finished, compare with the reference; arm stays high.
    task automatic run_op(input logic [K_W-1:0] k, input logic [X_W-1:0] x,
                          input string req, output int lat);
        logic [Y_W-1:0] exp;
        exp = ref_mul(k, x);
        @(negedge clk);
        coef = k; opnd = x; arm = 1'b1; lat = 0;
        do begin
            @(posedge clk); #1; lat++;
        end while (!finished && lat < 200);
        chk(result == exp, req, result, exp);
    endtask

    task automatic drop_arm();
        @(negedge clk); arm = 1'b0;
        @(posedge clk); #1;
        chk(finished == 1'b0, "R8", finished, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(finished == 1'b0, "R1", finished, 0);
        chk(result == '0, "R1", result, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_basic();
        int lat;
        // 3.5 x -2.25
        run_op(48'sd7 <<< 39, -20'sd576, "R2", lat);
        // Counting includes the arming edge, so the expected count is X_W+2.
        chk(lat == X_W + 2, "R6", lat, X_W + 2);
        drop_arm();
        run_op(48'h0000_0123_4567, 20'h00345, "R2", lat);
        drop_arm();
    endtask

    task automatic t_trunc();
        int lat;
        run_op(48'd1, {X_W{1'b1}}, "R3", lat);
        chk(result == {Y_W{1'b1}}, "R3", result, {Y_W{1'b1}});
        drop_arm();
        run_op(48'd1, 20'd255, "R3", lat);
        chk(result == '0, "R3", result, 0);
        drop_arm();
    endtask

    task automatic t_zero();
        int lat;
        run_op('0, 20'h7FFFF, "R10", lat);
        chk(result == '0, "R10", result, 0);
        drop_arm();
        run_op(48'h7FFF_FFFF_FFFF, '0, "R10", lat);
        chk(result == '0, "R10", result, 0);
        drop_arm();
    endtask

    task automatic t_sat();
        int lat;
        run_op(48'h7FFF_FFFF_FFFF, 20'h7FFFF, "R4", lat);
        chk(result == Y_MAX, "R4", result, Y_MAX);
        drop_arm();
        run_op(48'h8000_0000_0000, 20'h80000, "R4", lat);
        chk(result == Y_MAX, "R4", result, Y_MAX);
        drop_arm();
        run_op(48'h7FFF_FFFF_FFFF, 20'h80000, "R5", lat);
        chk(result == Y_MIN, "R5", result, Y_MIN);
        drop_arm();
        run_op(48'h8000_0000_0000, 20'h7FFFF, "R5", lat);
        chk(result == Y_MIN, "R5", result, Y_MIN);
        drop_arm();
    endtask

    task automatic t_capture();
        logic [Y_W-1:0] exp;
        int lat;
        exp = ref_mul(48'h0012_3456_789A, 20'hFF00D);
        @(negedge clk);
        coef = 48'h0012_3456_789A; opnd = 20'hFF00D; arm = 1'b1;
        @(negedge clk);
        coef = 48'h7FFF_0000_FFFF; opnd = 20'h12345;
        lat = 0;
        do begin
            @(posedge clk); #1; lat++;
        end while (!finished && lat < 200);
        chk(result == exp, "R9", result, exp);
        drop_arm();
    endtask

    task automatic t_hold();
        logic [Y_W-1:0] held;
        int lat;
        run_op(48'h0000_4000_0000, 20'h00100, "R2", lat);
        held = result;
        @(negedge clk); coef = 48'h7FFF_FFFF_FFFF; opnd = 20'h7FFFF;
        repeat (X_W + 4) @(posedge clk);
        #1;
        chk(finished == 1'b1, "R7", finished, 1);
        chk(result == held, "R7", result, held);
        drop_arm();
        // Re-arm one cycle after release: a normal operation follows.
        run_op(48'hFFFF_FF00_0000, 20'h00C00, "R8", lat);
        chk(lat == X_W + 2, "R8", lat, X_W + 2);
        drop_arm();
    endtask

    task automatic t_random();
        int lat;
        for (int i = 0; i < 24; i++) begin
            logic [K_W-1:0] k;
            logic [X_W-1:0] x;
            k = {$urandom(), $urandom()};
            x = $urandom();
            if (i % 2 == 0) k = {{12{k[35]}}, k[35:0]};
            run_op(k, x, "R2", lat);
            drop_arm();
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #4ms;
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_trunc();
        t_zero();
        t_sat();
        t_capture();
        t_hold();
        t_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule